// File: doc/BRIEF.md
# Charge Cycle Sequencer

This block steps a single battery channel through the phases of a charge cycle. Analog comparators and a separate termination detector feed it flags. It runs an optional discharge first. It then qualifies the battery's voltage and temperature, fast charges it, optionally tops it off, and settles into maintenance trickle. It also recognises a removed battery. A 3-bit phase code tells a downstream current modulator how to gate the charge current. Three further outputs drive the discharge transistor, a status LED and a fast-charge-complete line.

All timing comes from a single strobe, `tick8`, which pulses once every eighth of a second. That strobe sets the LED flash rate. Eight strobes make one second for the safety timers and for the over-voltage qualification window. The discharge command is an asynchronous, active-low level. It is synchronised and debounced before use.

Top module: `charge_seq`

## Requirements
- R1: While `supplyOk` is low, the phase is OFF (code 0), `dischOn` is 0, `statusLed` is 0 and `fastDoneN` is 1.
- R2: When the supply becomes valid, a new cycle starts. It enters DISCH (code 1) if the filtered discharge command is held low, otherwise PEND (code 2). While in OFF, a command edge has no effect.
- R3: In DISCH, `dischOn` is 1. The phase stays DISCH until `cellLow` is 1, then moves to PEND with `dischOn` back at 0.
- R4: A falling edge on `dischCmdN` starts DISCH from any phase except OFF. The edge must be stable for DEB_CYC clocks after a two-flop synchroniser.
- R5: In PEND, the phase stays PEND with no time limit while `cellLow` or `tempOut` is 1. It moves to FAST (code 3) once both are 0.
- R6: `cellHigh` in PEND or TRICKLE (code 6) moves the phase to ABSENT (code 7). ABSENT holds while `cellHigh` is 1. When `cellHigh` falls, a new cycle starts.
- R7: In FAST, `termReq` or `tempCut` ends fast charge. The next phase is TOPOFF (code 5) if `topoffEn` is 1, otherwise TRICKLE.
- R8: `cellHigh` in FAST moves the phase to HOLD (code 4), with no charge current. If `cellHigh` clears before OV_TICKS strobes, the phase goes to TRICKLE. If it is still set after OV_TICKS strobes, the phase goes to ABSENT.
- R9: FAST ends after SAFE_SECS seconds (8·SAFE_SECS strobes). The timer restarts for TOPOFF, which ends the same way into TRICKLE. TRICKLE has no time limit.
- R10: TOPOFF ends only on `cellHigh`, `tempCut` or timeout, always into TRICKLE. `termReq` has no effect there.
- R11: `statusLed` behaves as follows:
  - In DISCH and PEND it toggles on every `tick8`.
  - In OFF, FAST and HOLD it is 0.
  - In TOPOFF, TRICKLE and ABSENT it is 1.

  `fastDoneN` is 0 exactly in TOPOFF and TRICKLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| supplyOk | input | 1 | Charging supply is valid |
| cellLow | input | 1 | Cell voltage below end-of-discharge level |
| cellHigh | input | 1 | Cell voltage above maximum level |
| tempOut | input | 1 | Temperature outside the charge window |
| tempCut | input | 1 | Temperature beyond the hot cut-off |
| termReq | input | 1 | Fast-charge termination from detector |
| dischCmdN | input | 1 | Asynchronous active-low discharge command |
| topoffEn | input | 1 | Top-off phase selected |
| tick8 | input | 1 | One-cycle strobe every 1/8 s |
| phase | output | 3 | Phase code for the modulator |
| dischOn | output | 1 | Discharge transistor enable |
| statusLed | output | 1 | Charge status LED |
| fastDoneN | output | 1 | Low after fast charge has terminated |

## Verification
The bench targets the over-voltage window from both sides: clearing on the last strobe before expiry and persisting through it. A design that counted one strobe too few or too many would report a battery removal as a completed charge, or the reverse. It tests the safety timer one strobe before and at expiry, in both fast charge and top-off. A timer that was not restarted for top-off would cut top-off short. It confirms that a termination request is ignored during top-off and that a command held low through power-off starts discharge only as the first step of the next cycle. A randomized run then checks that the LED, complete and discharge outputs always match the reported phase.

// File: rtl/chg_pkg.sv
package chg_pkg;
  typedef enum logic [2:0] {
    PH_OFF     = 3'd0,
    PH_DISCH   = 3'd1,
    PH_PEND    = 3'd2,
    PH_FAST    = 3'd3,
    PH_HOLD    = 3'd4,
    PH_TOPOFF  = 3'd5,
    PH_TRICKLE = 3'd6,
    PH_ABSENT  = 3'd7
  } phase_t;

  typedef struct packed {
    logic clr;
    logic runSafe;
    logic runOv;
  } strobe_t;
endpackage

// File: rtl/chg_dp.sv
module chg_dp import chg_pkg::*; #(
  parameter int SAFE_SECS = 5400,
  parameter int OV_TICKS  = 8,
  parameter int DEB_CYC   = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    tick8,
  input  logic    dischCmdN,
  input  strobe_t strobe,
  output logic    safeExpired,
  output logic    ovExpired,
  output logic    blink,
  output logic    cmdLow,
  output logic    cmdFall
);
  localparam int SW = $clog2(SAFE_SECS + 1);
  localparam int OW = $clog2(OV_TICKS + 1);
  localparam int DW = $clog2(DEB_CYC + 1);

  logic [2:0]    subSec;
  logic [SW-1:0] secs;
  logic [OW-1:0] ovCnt;
  logic          syncA, syncB, filt;
  logic [DW-1:0] debCnt;

  assign safeExpired = (secs >= SW'(SAFE_SECS));
  assign ovExpired   = (ovCnt >= OW'(OV_TICKS));
  assign cmdLow      = ~filt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      subSec <= '0;
      secs   <= '0;
      ovCnt  <= '0;
      blink  <= 1'b0;
    end else begin
      if (tick8) blink <= ~blink;
      if (strobe.clr) begin
        subSec <= '0;
        secs   <= '0;
      end else if (strobe.runSafe && tick8 && !safeExpired) begin
        subSec <= subSec + 3'd1;
        if (subSec == 3'd7) secs <= secs + SW'(1);
      end
      if (strobe.clr) ovCnt <= '0;
      else if (strobe.runOv && tick8 && !ovExpired) ovCnt <= ovCnt + OW'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA   <= 1'b1;
      syncB   <= 1'b1;
      filt    <= 1'b1;
      debCnt  <= '0;
      cmdFall <= 1'b0;
    end else begin
      syncA   <= dischCmdN;
      syncB   <= syncA;
      cmdFall <= 1'b0;
      if (syncB == filt) begin
        debCnt <= '0;
      end else if (debCnt == DW'(DEB_CYC - 1)) begin
        filt    <= syncB;
        debCnt  <= '0;
        cmdFall <= filt & ~syncB;
      end else begin
        debCnt <= debCnt + DW'(1);
      end
    end
  end

  assert_safe_rise_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(safeExpired) |-> $past(strobe.runSafe) && $past(tick8));
  assert_ov_rise_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ovExpired) |-> $past(strobe.runOv) && $past(tick8));
endmodule

// File: rtl/chg_ctrl.sv
module chg_ctrl import chg_pkg::*; (
  input  logic    clk,
  input  logic    rstN,
  input  logic    supplyOk,
  input  logic    cellLow,
  input  logic    cellHigh,
  input  logic    tempOut,
  input  logic    tempCut,
  input  logic    termReq,
  input  logic    topoffEn,
  input  logic    safeExpired,
  input  logic    ovExpired,
  input  logic    blink,
  input  logic    cmdLow,
  input  logic    cmdFall,
  output strobe_t strobe,
  output logic [2:0] phase,
  output logic    dischOn,
  output logic    statusLed,
  output logic    fastDoneN
);
  phase_t state, stateNext, startPhase;

  assign startPhase = cmdLow ? PH_DISCH : PH_PEND;

  always_comb begin
    stateNext = state;
    if (!supplyOk) begin
      stateNext = PH_OFF;
    end else if (cmdFall && state != PH_OFF) begin
      stateNext = PH_DISCH;
    end else begin
      unique case (state)
        PH_OFF:     stateNext = startPhase;
        PH_DISCH:   if (cellLow) stateNext = PH_PEND;
        PH_PEND: begin
          if (cellHigh) stateNext = PH_ABSENT;
          else if (!cellLow && !tempOut) stateNext = PH_FAST;
        end
        PH_FAST: begin
          if (cellHigh) stateNext = PH_HOLD;
          else if (termReq || tempCut || safeExpired)
            stateNext = topoffEn ? PH_TOPOFF : PH_TRICKLE;
        end
        PH_HOLD: begin
          if (!cellHigh) stateNext = PH_TRICKLE;
          else if (ovExpired) stateNext = PH_ABSENT;
        end
        PH_TOPOFF:  if (cellHigh || tempCut || safeExpired) stateNext = PH_TRICKLE;
        PH_TRICKLE: if (cellHigh) stateNext = PH_ABSENT;
        PH_ABSENT:  if (!cellHigh) stateNext = startPhase;
        default:    stateNext = PH_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= PH_OFF;
    else       state <= stateNext;
  end

  always_comb begin
    strobe.clr     = (stateNext != state);
    strobe.runSafe = (state == PH_FAST) || (state == PH_TOPOFF);
    strobe.runOv   = (state == PH_HOLD);
  end

  assign phase     = state;
  assign dischOn   = (state == PH_DISCH);
  assign fastDoneN = !((state == PH_TOPOFF) || (state == PH_TRICKLE));

  always_comb begin
    unique case (state)
      PH_DISCH, PH_PEND:                 statusLed = blink;
      PH_TOPOFF, PH_TRICKLE, PH_ABSENT:  statusLed = 1'b1;
      default:                           statusLed = 1'b0;
    endcase
  end

  assert_supply_off_R1: assert property (@(posedge clk) disable iff (!rstN)
    !supplyOk |=> phase == 3'd0);
  assert_pend_waits_R5: assert property (@(posedge clk) disable iff (!rstN)
    (state == PH_PEND) && supplyOk && !cmdFall && !cellHigh && (cellLow || tempOut)
      |=> phase == 3'd2);
  assert_absent_holds_R6: assert property (@(posedge clk) disable iff (!rstN)
    (state == PH_ABSENT) && supplyOk && !cmdFall && cellHigh |=> phase == 3'd7);
  assert_ov_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (state == PH_FAST) && supplyOk && !cmdFall && cellHigh |=> phase == 3'd4);
  assert_topoff_ignores_term_R10: assert property (@(posedge clk) disable iff (!rstN)
    (state == PH_TOPOFF) && supplyOk && !cmdFall && !cellHigh && !tempCut && !safeExpired
      |=> phase == 3'd5);
endmodule

// File: rtl/charge_seq.sv
module charge_seq import chg_pkg::*; #(
  parameter int SAFE_SECS = 5400,
  parameter int OV_TICKS  = 8,
  parameter int DEB_CYC   = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       supplyOk,
  input  logic       cellLow,
  input  logic       cellHigh,
  input  logic       tempOut,
  input  logic       tempCut,
  input  logic       termReq,
  input  logic       dischCmdN,
  input  logic       topoffEn,
  input  logic       tick8,
  output logic [2:0] phase,
  output logic       dischOn,
  output logic       statusLed,
  output logic       fastDoneN
);
  strobe_t strobe;
  logic safeExpired, ovExpired, blink, cmdLow, cmdFall;

  chg_dp #(.SAFE_SECS(SAFE_SECS), .OV_TICKS(OV_TICKS), .DEB_CYC(DEB_CYC)) uDp (
    .clk(clk), .rstN(rstN), .tick8(tick8), .dischCmdN(dischCmdN), .strobe(strobe),
    .safeExpired(safeExpired), .ovExpired(ovExpired), .blink(blink),
    .cmdLow(cmdLow), .cmdFall(cmdFall));

  chg_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .supplyOk(supplyOk), .cellLow(cellLow), .cellHigh(cellHigh),
    .tempOut(tempOut), .tempCut(tempCut), .termReq(termReq), .topoffEn(topoffEn),
    .safeExpired(safeExpired), .ovExpired(ovExpired), .blink(blink), .cmdLow(cmdLow),
    .cmdFall(cmdFall), .strobe(strobe), .phase(phase), .dischOn(dischOn),
    .statusLed(statusLed), .fastDoneN(fastDoneN));
endmodule

// File: tb/tb_charge_seq.sv
module tb_charge_seq;
  localparam int SAFE = 3;
  localparam int OVT  = 8;

  logic clk = 1'b0;
  logic rstN, supplyOk, cellLow, cellHigh, tempOut, tempCut, termReq, dischCmdN, topoffEn, tick8;
  logic [2:0] phase;
  logic dischOn, statusLed, fastDoneN;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  charge_seq #(.SAFE_SECS(SAFE), .OV_TICKS(OVT), .DEB_CYC(2)) dut (
    .clk(clk), .rstN(rstN), .supplyOk(supplyOk), .cellLow(cellLow), .cellHigh(cellHigh),
    .tempOut(tempOut), .tempCut(tempCut), .termReq(termReq), .dischCmdN(dischCmdN),
    .topoffEn(topoffEn), .tick8(tick8), .phase(phase), .dischOn(dischOn),
    .statusLed(statusLed), .fastDoneN(fastDoneN));

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      tick8 = 1'b1; step(1);
      tick8 = 1'b0; step(1);
    end
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int ledSteady(input int ph);
    return (ph == 5 || ph == 6 || ph == 7) ? 1 : 0;
  endfunction

  function automatic int doneExp(input int ph);
    return (ph == 5 || ph == 6) ? 0 : 1;
  endfunction

  task automatic toFast();
    dischCmdN = 1'b0; step(8); dischCmdN = 1'b1; step(8);
    cellLow = 1'b1; step(2);
    cellLow = 1'b0; step(1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    int l0;
    seed = $urandom(32'd1234);
    rstN = 0; supplyOk = 0; cellLow = 1; cellHigh = 0; tempOut = 0; tempCut = 0;
    termReq = 0; dischCmdN = 1; topoffEn = 1; tick8 = 0;
    step(3); rstN = 1; step(2);
    chk("R1 phase", phase, 0); chk("R1 dischOn", dischOn, 0);
    chk("R1 led", statusLed, 0); chk("R1 done", fastDoneN, 1);

    supplyOk = 1; step(2);
    chk("R2 start pend", phase, 2);
    l0 = statusLed; tick(1);
    chk("R11 flash toggles", statusLed, 1 - l0);
    step(3); chk("R5 waits low", phase, 2);
    cellLow = 0; tempOut = 1; step(3); chk("R5 waits temp", phase, 2);
    tempOut = 0; step(2); chk("R5 to fast", phase, 3); chk("R11 fast led", statusLed, 0);

    termReq = 1; step(2);
    chk("R7 topoff", phase, 5); chk("R11 done low", fastDoneN, 0); chk("R11 led high", statusLed, 1);
    step(3); chk("R10 term ignored", phase, 5);
    termReq = 0;
    tick(8 * SAFE - 1); chk("R9 topoff before limit", phase, 5);
    tick(1); chk("R9 topoff timeout", phase, 6);
    tick(40); chk("R9 trickle no limit", phase, 6);

    cellHigh = 1; step(2); chk("R6 absent", phase, 7); chk("R11 absent led", statusLed, 1);
    step(4); chk("R6 absent holds", phase, 7);
    cellHigh = 0; step(1); chk("R6 restart", phase, 2);
    step(1); chk("R5 fast again", phase, 3);

    cellHigh = 1; step(1); chk("R8 hold", phase, 4); chk("R11 hold led", statusLed, 0);
    tick(OVT - 1); chk("R8 hold before window", phase, 4);
    cellHigh = 0; step(2); chk("R8 short ov complete", phase, 6);

    dischCmdN = 0; step(8); chk("R4 discharge", phase, 1); chk("R3 dischOn", dischOn, 1);
    dischCmdN = 1; step(8); chk("R3 stays", phase, 1);
    cellLow = 1; step(2); chk("R3 to pend", phase, 2); chk("R3 off", dischOn, 0);
    cellLow = 0; step(1); chk("R5 fast", phase, 3);
    topoffEn = 0; tempCut = 1; step(2); chk("R7 trickle", phase, 6);
    tempCut = 0;

    toFast(); chk("R4 fast via discharge", phase, 3);
    cellHigh = 1; step(1); tick(OVT); chk("R8 long ov absent", phase, 7);
    cellHigh = 0;

    supplyOk = 0; step(2); chk("R1 off", phase, 0);
    dischCmdN = 0; step(8); chk("R2 edge ignored in off", phase, 0);
    supplyOk = 1; step(2); chk("R2 start disch", phase, 1);
    dischCmdN = 1; step(8);
    cellLow = 1; step(2); cellLow = 0; step(1);
    topoffEn = 1;
    tick(8 * SAFE - 1); chk("R9 fast before limit", phase, 3);
    tick(1); chk("R9 fast timeout", phase, 5);

    for (int i = 0; i < 500; i++) begin
      bit supWas;
      supplyOk  = ($urandom % 16) != 0;
      cellLow   = ($urandom % 4) == 0;
      cellHigh  = ($urandom % 8) == 0;
      tempOut   = ($urandom % 4) == 0;
      tempCut   = ($urandom % 8) == 0;
      termReq   = ($urandom % 8) == 0;
      topoffEn  = $urandom % 2;
      tick8     = $urandom % 2;
      if (($urandom % 16) == 0) dischCmdN = ~dischCmdN;
      supWas = supplyOk;
      step(1);
      if (!supWas) chk("R1 random off", phase, 0);
      chk("R11 random done", fastDoneN, doneExp(phase));
      chk("R3 random dischOn", dischOn, (phase == 1) ? 1 : 0);
      if (phase != 1 && phase != 2) chk("R11 random led", statusLed, ledSteady(phase));
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule